// File: doc/BRIEF.md
# Serial port status and interrupt register block

This block is the control and status register set for a byte-wide asynchronous serial port that sits underneath an infrared link. The transmit and receive shifters live outside it. They report what happens as single-cycle event pulses: a byte arrived (with its data), a parity, framing or checksum error was seen, the transmitter moved the buffered byte into its shift register, and the shift register ran empty. Software reaches the block through a simple register read/write port. One level-sensitive interrupt line summarises every status flag whose mask bit is set.

Transmit completion has two levels. The transmit buffer and the transmit shift register each have their own flag and their own mask bit. A transfer is finished only when both flags are set. On the receive side, one read of the receive data register acknowledges the byte and clears every pending receive error. A separate error copy register keeps a sticky record of the errors until software writes zeros to it. When a byte arrives while the previous one has not been read, an overrun is flagged and the older byte is kept.

Top module: `sir_stat_irq`

## Requirements
- R1: After a synchronous active-low reset, the control register (address 0) reads 0, the mask register (address 2) reads 0, the error copy register (address 5) reads 0, and the status register (address 1) reads 0x0003. In the status register, bit0 is transmit buffer empty and bit1 is shift register empty. `irq` is 0 and `tx_done` is 1.
- R2: In the control register, bit0 is transmit enable and bit1 is receive enable. Both bits read back and drive `tx_enable` and `rx_enable`. Bit2 is a write-only transmit-data clear and always reads 0.
- R3: A write to the transmit data register (address 3) puts the low byte on `tx_byte` and clears status bit0. A `tx_load_stb` pulse sets bit0 and clears bit1. A `tx_shift_done` pulse sets bit1.
- R4: Writing the control register with bit2 set empties the transmit buffer and sets status bit0. It leaves status bit1 unchanged.
- R5: `tx_done` is 1 only when status bit0 and bit1 are both 1.
- R6: While receive is enabled, a `rx_byte_stb` pulse into an empty receiver stores the byte and sets status bit2 (receive full). A read of the receive data register (address 4) returns that byte in the low eight bits.
- R7: A byte that arrives while bit2 is still set sets status bit5 (overrun). The stored byte is left unchanged.
- R8: Parity, framing and checksum error pulses set status bits 3, 4 and 6. A read of address 4 clears status bits 2 through 6.
- R9: The error copy register holds the same four errors in the same positions (bits 3, 4, 5 and 6). A read of address 4 does not clear it. A write to address 5 clears each bit written as 0 and keeps each bit written as 1.
- R10: While receive enable is 0, byte and error pulses have no effect on the status register or the error copy register.
- R11: The mask register keeps only bits 0, 1, 2 and 6, so writing 0xFFFF reads back 0x0047. `irq` is 1 while any status bit and its mask bit are both 1. It stays 1 until the flag or the mask bit is cleared.
- R12: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 4 has a side effect |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, valid in the same cycle |
| rx_byte_stb | input | 1 | Receiver delivered a byte |
| rx_byte_data | input | 8 | Byte delivered with `rx_byte_stb` |
| rx_parity_err | input | 1 | Receiver saw a parity error |
| rx_frame_err | input | 1 | Receiver saw a framing error |
| rx_sum_err | input | 1 | Receiver saw a checksum error |
| tx_load_stb | input | 1 | Transmitter moved the buffered byte into its shift register |
| tx_shift_done | input | 1 | Transmit shift register ran empty |
| tx_byte | output | 8 | Byte waiting in the transmit buffer |
| tx_enable | output | 1 | Transmit enable control bit |
| rx_enable | output | 1 | Receive enable control bit |
| tx_done | output | 1 | Buffer and shift register both empty |
| irq | output | 1 | Combined masked interrupt, level held |

## Verification
Each flag register feeds straight into the status read mux and the interrupt OR. A flag that is set, cleared or kept wrongly therefore shows up on the first status or error copy read after the event, one clock after the pulse. It shows up on `irq` in that same cycle for every bit whose mask is set. Overrun and read-clear faults also change what address 4 returns, and the stored byte is compared directly. The two transmit flags can fail independently of each other, so every transmit step is followed by a status read and a `tx_done` check.

// File: rtl/sir_regs_pkg.sv
// Package: address map and bit positions shared by the serial status block.
// Assumes a flat 3-bit register address space and a 7-bit status vector.
package sir_regs_pkg;
    localparam int ADDR_W = 3;
    localparam int STAT_W = 7;
    localparam int ERR_N  = 4;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_TXD  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_RXD  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_ERRC = 3'd5;

    // status / mask bit positions
    localparam int B_TXE = 0;
    localparam int B_TSE = 1;
    localparam int B_RXF = 2;
    localparam int B_PAR = 3;
    localparam int B_FRM = 4;
    localparam int B_OVR = 5;
    localparam int B_SUM = 6;

    // control bit positions
    localparam int C_TXEN  = 0;
    localparam int C_RXEN  = 1;
    localparam int C_TXCLR = 2;

    // mask bits that software may set
    localparam logic [STAT_W-1:0] MASK_WRITABLE = 7'b100_0111;
endpackage

// File: rtl/sir_tx_flags.sv
// Module: transmit buffer and shift-register flags.
// Holds the byte written by software and the two transmit-empty flags.
// Assumes single-cycle event pulses; clear beats write, write beats load.
module sir_tx_flags #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              clr_stb,
    input  logic              load_stb,
    input  logic              shift_done,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_done
);
    // Buffer-empty flag: set by clear or by the transmitter taking the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        buf_empty <= 1'b1;
        else if (clr_stb)  buf_empty <= 1'b1;
        else if (wr_stb)   buf_empty <= 1'b0;
        else if (load_stb) buf_empty <= 1'b1;
    end

    // Shift-empty flag: cleared on load, set when the last bit has left.
    always_ff @(posedge clk) begin
        if (!rst_n)          shift_empty <= 1'b1;
        else if (load_stb)   shift_empty <= 1'b0;
        else if (shift_done) shift_empty <= 1'b1;
    end

    // Transmit byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tx_byte <= '0;
        else if (wr_stb && !clr_stb) tx_byte <= wr_byte;
    end

    // Completion needs both levels empty.
    always_comb tx_done = buf_empty & shift_empty;

    assert_wr_clears_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !clr_stb) |=> (!buf_empty && tx_byte == $past(wr_byte)));
    assert_load_moves_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !wr_stb && !clr_stb) |=> (buf_empty && !shift_empty));
    assert_clear_sets_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !load_stb && !shift_done) |=> (buf_empty && $stable(shift_empty)));
endmodule

// File: rtl/sir_rx_flags.sv
// Module: receive byte store, receive-full flag, error flags and sticky error copy.
// Error vector order: index 0 parity, 1 framing, 2 overrun, 3 checksum.
// Assumes event pulses are already synchronous; a data read and an arrival
// in the same cycle store the new byte without raising overrun.
module sir_rx_flags #(
    parameter int BYTE_W = 8,
    parameter int ERR_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              par_err,
    input  logic              frm_err,
    input  logic              sum_err,
    input  logic              data_rd,
    input  logic              copy_wr,
    input  logic [ERR_N-1:0]  copy_wdata,
    output logic              rx_full,
    output logic [ERR_N-1:0]  err,
    output logic [ERR_N-1:0]  err_copy,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int I_OVR = 2;

    logic             byte_in;
    logic             ovr_now;
    logic [ERR_N-1:0] err_new;
    logic [ERR_N-1:0] keep_mask;

    // Gate events by receive enable and form this cycle's new error set.
    always_comb begin
        byte_in   = rx_en & byte_stb;
        ovr_now   = byte_in & rx_full & ~data_rd;
        err_new   = {rx_en & sum_err, ovr_now, rx_en & frm_err, rx_en & par_err};
        keep_mask = copy_wr ? copy_wdata : '1;
    end

    // Receive-full flag: set on arrival, cleared by the data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_full <= 1'b0;
        else if (byte_in) rx_full <= 1'b1;
        else if (data_rd) rx_full <= 1'b0;
    end

    // Byte store: a byte arriving over an unread one is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                               rx_byte <= '0;
        else if (byte_in && (!rx_full || data_rd)) rx_byte <= byte_data;
    end

    // One flag and one sticky copy per error kind.
    for (genvar g = 0; g < ERR_N; g++) begin : g_err
        // Live error flag: new events accumulate, a data read acknowledges.
        always_ff @(posedge clk) begin
            if (!rst_n)       err[g] <= 1'b0;
            else if (data_rd) err[g] <= err_new[g];
            else              err[g] <= err[g] | err_new[g];
        end

        // Sticky copy: cleared only by writing zero; a new event wins.
        always_ff @(posedge clk) begin
            if (!rst_n) err_copy[g] <= 1'b0;
            else        err_copy[g] <= (err_copy[g] & keep_mask[g]) | err_new[g];
        end
    end

    assert_overrun_keeps_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && byte_stb && rx_full && !data_rd) |=> (err[I_OVR] && $stable(rx_byte)));
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !byte_stb && !par_err && !frm_err && !sum_err) |=> (!rx_full && err == '0));
    assert_copy_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_wr |=> ((err_copy & $past(err_copy)) == $past(err_copy)));
    assert_disabled_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !data_rd && !copy_wr) |=> ($stable(rx_full) && $stable(err) && $stable(err_copy)));
endmodule

// File: rtl/sir_irq_ctrl.sv
// Module: interrupt mask register and combined level interrupt.
// Assumes the status vector is registered upstream; irq follows it combinationally.
module sir_irq_ctrl #(
    parameter int                STAT_W   = 7,
    parameter logic [STAT_W-1:0] WR_MASK  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);
    // Mask register: only the enable positions that exist are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_wdata & WR_MASK;
    end

    // Level interrupt: any enabled flag that is set.
    always_comb irq = |(status & mask);

    assert_mask_zero_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata == '0) |=> !irq);
endmodule

// File: rtl/sir_stat_irq.sv
// Module: top of the serial port status and interrupt register block.
// Decodes the register port, holds the control bits, assembles the status
// and error-copy views and instantiates the transmit, receive and interrupt parts.
// Assumes reg_rd and reg_wr are one-cycle strobes and read data is used in
// the same cycle as the strobe.
module sir_stat_irq
    import sir_regs_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rx_byte_stb,
    input  logic [BYTE_W-1:0] rx_byte_data,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_sum_err,
    input  logic              tx_load_stb,
    input  logic              tx_shift_done,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              tx_done,
    output logic              irq
);
    localparam int PAD_S = REG_W - STAT_W;
    localparam int PAD_B = REG_W - BYTE_W;

    logic              wr_ctrl, wr_mask, wr_txd, wr_errc, rd_rxd, clr_stb;
    logic              buf_empty, shift_empty, rx_full;
    logic [ERR_N-1:0]  err, err_copy;
    logic [BYTE_W-1:0] rx_byte;
    logic [STAT_W-1:0] status, copy_view, mask;

    // Address decode of the register strobes.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
        wr_mask = reg_wr && (reg_addr == ADR_MASK);
        wr_txd  = reg_wr && (reg_addr == ADR_TXD);
        wr_errc = reg_wr && (reg_addr == ADR_ERRC);
        rd_rxd  = reg_rd && (reg_addr == ADR_RXD);
        clr_stb = wr_ctrl && reg_wdata[C_TXCLR];
    end

    // Control bits: transmit and receive enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_enable <= 1'b0;
            rx_enable <= 1'b0;
        end else if (wr_ctrl) begin
            tx_enable <= reg_wdata[C_TXEN];
            rx_enable <= reg_wdata[C_RXEN];
        end
    end

    sir_tx_flags #(.BYTE_W(BYTE_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_txd),
        .wr_byte     (reg_wdata[BYTE_W-1:0]),
        .clr_stb     (clr_stb),
        .load_stb    (tx_load_stb),
        .shift_done  (tx_shift_done),
        .buf_empty   (buf_empty),
        .shift_empty (shift_empty),
        .tx_byte     (tx_byte),
        .tx_done     (tx_done)
    );

    sir_rx_flags #(.BYTE_W(BYTE_W), .ERR_N(ERR_N)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_enable),
        .byte_stb   (rx_byte_stb),
        .byte_data  (rx_byte_data),
        .par_err    (rx_parity_err),
        .frm_err    (rx_frame_err),
        .sum_err    (rx_sum_err),
        .data_rd    (rd_rxd),
        .copy_wr    (wr_errc),
        .copy_wdata (reg_wdata[B_SUM:B_PAR]),
        .rx_full    (rx_full),
        .err        (err),
        .err_copy   (err_copy),
        .rx_byte    (rx_byte)
    );

    // Status and error-copy views in register bit positions.
    always_comb begin
        status    = {err, rx_full, shift_empty, buf_empty};
        copy_view = {err_copy, 3'b000};
    end

    sir_irq_ctrl #(.STAT_W(STAT_W), .WR_MASK(MASK_WRITABLE)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (wr_mask),
        .mask_wdata (reg_wdata[STAT_W-1:0]),
        .status     (status),
        .mask       (mask),
        .irq        (irq)
    );

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            ADR_CTRL: reg_rdata = {{(REG_W-2){1'b0}}, rx_enable, tx_enable};
            ADR_STAT: reg_rdata = {{PAD_S{1'b0}}, status};
            ADR_MASK: reg_rdata = {{PAD_S{1'b0}}, mask};
            ADR_RXD:  reg_rdata = {{PAD_B{1'b0}}, rx_byte};
            ADR_ERRC: reg_rdata = {{PAD_S{1'b0}}, copy_view};
            default:  reg_rdata = '0;
        endcase
    end

    assert_irq_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !reg_rd && !rx_byte_stb && !rx_parity_err && !rx_frame_err &&
         !rx_sum_err && !tx_load_stb && !tx_shift_done) |=> $stable(irq));
    assert_status_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_STAT && !rx_byte_stb && !rx_parity_err && !rx_frame_err &&
         !rx_sum_err && !tx_load_stb && !tx_shift_done) |=> $stable(status));
    assert_done_needs_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_stb |=> !tx_done);
endmodule

// File: tb/sir_stat_irq_bench.sv
`timescale 1ns/100ps
module sir_stat_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        rx_byte_stb, rx_parity_err, rx_frame_err, rx_sum_err;
    logic [7:0]  rx_byte_data, tx_byte;
    logic        tx_load_stb, tx_shift_done;
    logic        tx_enable, rx_enable, tx_done, irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // kinds: 0 read data, 1 irq, 2 tx_done, 3 tx_byte, 4 tx_enable, 5 rx_enable
    typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
    item_t sbq[$];
    item_t it;
    logic [15:0] act;

    always #2.5 clk = ~clk;

    sir_stat_irq u_sir_stat_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_byte_stb(rx_byte_stb), .rx_byte_data(rx_byte_data),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_sum_err(rx_sum_err), .tx_load_stb(tx_load_stb),
        .tx_shift_done(tx_shift_done), .tx_byte(tx_byte),
        .tx_enable(tx_enable), .rx_enable(rx_enable), .tx_done(tx_done), .irq(irq)
    );

    // Monitor: pops the item pushed at this falling edge and compares.
    always @(negedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            case (it.kind)
                0: act = reg_rdata;
                1: act = {15'd0, irq};
                2: act = {15'd0, tx_done};
                3: act = {8'd0, tx_byte};
                4: act = {15'd0, tx_enable};
                default: act = {15'd0, rx_enable};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic clr_in();
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        rx_byte_stb = 0; rx_byte_data = 0; rx_parity_err = 0; rx_frame_err = 0;
        rx_sum_err = 0; tx_load_stb = 0; tx_shift_done = 0;
    endtask

    task automatic t_idle();
        @(negedge clk); clr_in();
    endtask

    task automatic t_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); clr_in();
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic t_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        item_t x;
        @(negedge clk); clr_in();
        reg_rd = 1; reg_addr = a;
        x.kind = 0; x.exp = e; x.tag = tag;
        sbq.push_back(x);
    endtask

    task automatic t_port(input int k, input logic [15:0] e, input string tag);
        item_t x;
        @(negedge clk); clr_in();
        x.kind = k; x.exp = e; x.tag = tag;
        sbq.push_back(x);
    endtask

    task automatic t_ev(input logic bs, input logic [7:0] d, input logic par,
                        input logic frm, input logic sum, input logic ld, input logic sd);
        @(negedge clk); clr_in();
        rx_byte_stb = bs; rx_byte_data = d; rx_parity_err = par;
        rx_frame_err = frm; rx_sum_err = sum; tx_load_stb = ld; tx_shift_done = sd;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; clr_in();
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        t_rd(3'd0, 16'h0000, "R1 ctrl");
        t_rd(3'd1, 16'h0003, "R1 status");
        t_rd(3'd2, 16'h0000, "R1 mask");
        t_rd(3'd5, 16'h0000, "R1 errcopy");
        t_port(1, 16'h0, "R1 irq");
        t_port(2, 16'h1, "R1 tx_done");

        // R2 control bits
        t_wr(3'd0, 16'h0003);
        t_rd(3'd0, 16'h0003, "R2 ctrl readback");
        t_port(4, 16'h1, "R2 tx_enable");
        t_port(5, 16'h1, "R2 rx_enable");
        t_wr(3'd0, 16'h0007);
        t_rd(3'd0, 16'h0003, "R2 clear bit reads 0");

        // R3 / R5 transmit flags
        t_wr(3'd3, 16'h00A5);
        t_rd(3'd1, 16'h0002, "R3 write clears buffer-empty");
        t_port(3, 16'h00A5, "R3 tx_byte");
        t_port(2, 16'h0, "R5 tx_done with buffer full");
        t_ev(0, 8'h00, 0, 0, 0, 1, 0);
        t_rd(3'd1, 16'h0001, "R3 load sets empty, shift busy");
        t_port(2, 16'h0, "R5 tx_done with shift busy");
        t_ev(0, 8'h00, 0, 0, 0, 0, 1);
        t_rd(3'd1, 16'h0003, "R3 shift done");
        t_port(2, 16'h1, "R5 tx_done both empty");

        // R4 transmit clear leaves shift flag
        t_wr(3'd3, 16'h003C);
        t_ev(0, 8'h00, 0, 0, 0, 1, 0);
        t_wr(3'd3, 16'h005A);
        t_rd(3'd1, 16'h0000, "R3 both busy");
        t_wr(3'd0, 16'h0007);
        t_rd(3'd1, 16'h0001, "R4 clear sets buffer-empty only");

        // R12 status write ignored
        t_wr(3'd1, 16'h0000);
        t_rd(3'd1, 16'h0001, "R12 status write ignored");
        t_ev(0, 8'h00, 0, 0, 0, 0, 1);

        // R6 receive byte
        t_ev(1, 8'h81, 0, 0, 0, 0, 0);
        t_rd(3'd1, 16'h0007, "R6 receive full");
        t_rd(3'd4, 16'h0081, "R6 receive data");
        t_rd(3'd1, 16'h0003, "R6 read clears full");

        // R7 overrun
        t_ev(1, 8'h11, 0, 0, 0, 0, 0);
        t_ev(1, 8'h22, 0, 0, 0, 0, 0);
        t_rd(3'd1, 16'h0027, "R7 overrun flag");
        t_rd(3'd5, 16'h0020, "R9 copy has overrun");
        t_rd(3'd4, 16'h0011, "R7 old byte kept");
        t_rd(3'd1, 16'h0003, "R8 read clears overrun");
        t_rd(3'd5, 16'h0020, "R9 copy survives data read");

        // R8 error flags
        t_ev(0, 8'h00, 1, 1, 0, 0, 0);
        t_rd(3'd1, 16'h001B, "R8 parity and framing");
        t_ev(1, 8'h44, 0, 0, 1, 0, 0);
        t_rd(3'd1, 16'h005F, "R8 checksum with byte");
        t_rd(3'd5, 16'h0078, "R9 copy all errors");
        t_rd(3'd4, 16'h0044, "R8 data read");
        t_rd(3'd1, 16'h0003, "R8 errors cleared");

        // R9 write-zero clear
        t_wr(3'd5, 16'h0058);
        t_rd(3'd5, 16'h0058, "R9 clear one bit");
        t_wr(3'd5, 16'h0000);
        t_rd(3'd5, 16'h0000, "R9 clear all");

        // R10 receive disabled
        t_wr(3'd0, 16'h0001);
        t_port(5, 16'h0, "R10 rx_enable low");
        t_ev(1, 8'h77, 1, 0, 1, 0, 0);
        t_rd(3'd1, 16'h0003, "R10 status unchanged");
        t_rd(3'd5, 16'h0000, "R10 copy unchanged");
        t_wr(3'd0, 16'h0003);

        // R11 mask and interrupt
        t_wr(3'd2, 16'hFFFF);
        t_rd(3'd2, 16'h0047, "R11 mask writable bits");
        t_port(1, 16'h1, "R11 irq from empties");
        t_wr(3'd2, 16'h0004);
        t_port(1, 16'h0, "R11 irq masked off");
        t_ev(1, 8'h99, 0, 0, 0, 0, 0);
        t_port(1, 16'h1, "R11 irq on receive");
        t_idle();
        t_port(1, 16'h1, "R11 irq held");
        t_rd(3'd4, 16'h0099, "R11 data read");
        t_port(1, 16'h0, "R11 irq drops on read");
        t_wr(3'd2, 16'h0040);
        t_ev(0, 8'h00, 0, 0, 1, 0, 0);
        t_port(1, 16'h1, "R11 irq on checksum");
        t_rd(3'd4, 16'h0099, "R11 byte held");
        t_port(1, 16'h0, "R11 checksum acknowledged");
        t_wr(3'd2, 16'h0002);
        t_port(1, 16'h1, "R11 irq on shift-empty");
        t_wr(3'd3, 16'h0012);
        t_port(1, 16'h1, "R11 shift-empty still set");
        t_ev(0, 8'h00, 0, 0, 0, 1, 0);
        t_port(1, 16'h0, "R11 irq off while shifting");
        t_ev(0, 8'h00, 0, 0, 0, 0, 1);
        t_port(1, 16'h1, "R11 irq on shift done");

        t_idle();
        t_idle();
        done = 1;
        summary();
        $finish;
    end
endmodule